// File: doc/BRIEF.md
# Delay-Slot Next-PC Sequencer

This block keeps the architectural program counter of a pipeline with a single branch delay slot, together with the delayed-branch state and a count of committed steps. At each retirement the core reports whether the instruction faulted and, optionally, a branch target it produced. The block decides the next PC. A branch target does not redirect the PC straight away: it waits in a pending register for one more instruction, the delay slot, and takes effect when that instruction commits.

A step commits only when the retire strobe is high and the exception input is low. A step that faults is discarded and changes nothing. The core's exception vector logic is expected to redirect by other means. Decode, execute and vector computation sit outside the block. All outputs come straight from registers.

Top module: `dsq_pc_seq`

## Requirements
- R1: Reset (synchronous, active high) sets the PC to the parameter RESET_PC, clears the pending-branch valid flag and its target to zero, and sets the commit count to zero.
- R2: While the retire strobe is low, the PC, the pending-branch state and the count all keep their values.
- R3: A retire with the exception input high is discarded: the PC, the pending-branch state and the count all keep their values.
- R4: A committed step with no pending branch and no offered target sets the PC to the old PC plus 4, and leaves the pending register empty.
- R5: A committed step with no pending branch and a valid target sets the PC to the old PC plus 4 and loads the target into the pending register, with its valid flag set.
- R6: A committed step with a pending branch sets the PC to the pending target and clears the pending valid flag.
- R7: A target offered by the instruction in the delay slot (a pending branch exists) is ignored, so after that step the pending valid flag is low.
- R8: The count rises by exactly 1 on each committed step and wraps to zero from its all-ones value. CNT_W sets its width.
- R9: PC arithmetic is modulo 2^ADDR_W, so PC plus 4 from 2^ADDR_W-4 gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | One instruction retires this cycle |
| excp_i | input | 1 | The retiring instruction raised an exception |
| tgt_vld_i | input | 1 | The retiring instruction produced a branch target |
| tgt_i | input | ADDR_W | Branch target address |
| pc_o | output | ADDR_W | Architectural program counter |
| pend_vld_o | output | 1 | A delayed branch is waiting for the delay slot |
| pend_tgt_o | output | ADDR_W | Target of the waiting branch |
| count_o | output | CNT_W | Number of committed steps |

## Verification
The assertions assume that the retire, exception and target-valid inputs have defined values on every clock edge after reset. They do not assume that targets are word aligned, or that the instruction in a delay slot offers no target. The stimulus drives every input from the first cycle and keeps targets as multiples of four. On purpose, it sometimes offers targets in delay slots, so that the block has to drop them.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  // Classification of one clock's retirement
  typedef enum logic [1:0] {
    STEP_HOLD     = 2'd0,  // no retire, or retire discarded by exception
    STEP_SEQ      = 2'd1,  // sequential advance, nothing new pending
    STEP_ARM      = 2'd2,  // sequential advance, target captured as pending
    STEP_REDIRECT = 2'd3   // delay slot committed, pending target taken
  } step_kind_e;
endpackage

// File: rtl/dsq_next.sv
module dsq_next
  import dsq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              retire,
  input  logic              excp,
  input  logic              tgt_vld,
  input  logic [ADDR_W-1:0] tgt,
  input  logic [ADDR_W-1:0] pc,
  input  logic              pend_vld,
  input  logic [ADDR_W-1:0] pend_tgt,
  output step_kind_e        kind,
  output logic              commit,
  output logic [ADDR_W-1:0] pc_nxt,
  output logic              pend_vld_nxt,
  output logic [ADDR_W-1:0] pend_tgt_nxt
);
  localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

  logic [ADDR_W-1:0] pc_seq;

  assign commit = retire & ~excp;
  assign pc_seq = pc + INSN_BYTES;

  always_comb begin
    if (!commit)        kind = STEP_HOLD;
    else if (pend_vld)  kind = STEP_REDIRECT;
    else if (tgt_vld)   kind = STEP_ARM;
    else                kind = STEP_SEQ;
  end

  always_comb begin
    pc_nxt       = pc;
    pend_vld_nxt = pend_vld;
    pend_tgt_nxt = pend_tgt;
    case (kind)
      STEP_SEQ: begin
        pc_nxt       = pc_seq;
        pend_vld_nxt = 1'b0;
      end
      STEP_ARM: begin
        pc_nxt       = pc_seq;
        pend_vld_nxt = 1'b1;
        pend_tgt_nxt = tgt;
      end
      STEP_REDIRECT: begin
        // target offered by the delay-slot instruction is dropped (R7)
        pc_nxt       = pend_tgt;
        pend_vld_nxt = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dsq_state.sv
module dsq_state #(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic              retire,
  input  logic [ADDR_W-1:0] pc_nxt,
  input  logic              pend_vld_nxt,
  input  logic [ADDR_W-1:0] pend_tgt_nxt,
  output logic [ADDR_W-1:0] pc_q,
  output logic              pend_vld_q,
  output logic [ADDR_W-1:0] pend_tgt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q       <= RESET_PC;
      pend_vld_q <= 1'b0;
      pend_tgt_q <= '0;
    end else if (commit) begin
      pc_q       <= pc_nxt;
      pend_vld_q <= pend_vld_nxt;
      pend_tgt_q <= pend_tgt_nxt;
    end
  end

  // R2: idle cycles leave PC and pending state untouched
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !retire |=> ($stable(pc_q) && $stable(pend_vld_q) && $stable(pend_tgt_q)));

  // R3: a faulting retire leaves PC and pending state untouched
  a_r3_excp_hold: assert property (@(posedge clk) disable iff (rst)
    (retire && !commit) |=> ($stable(pc_q) && $stable(pend_vld_q) && $stable(pend_tgt_q)));

  // R6: committing the delay slot jumps to the pending target and empties it
  a_r6_redirect: assert property (@(posedge clk) disable iff (rst)
    (commit && pend_vld_q) |=> (!pend_vld_q && pc_q == $past(pend_tgt_q)));

  // R4 / R9: without a pending branch the PC advances by one word, modulo 2^ADDR_W
  a_r4_seq_advance: assert property (@(posedge clk) disable iff (rst)
    (commit && !pend_vld_q) |=> (pc_q == $past(pc_q) + ADDR_W'(4)));
endmodule

// File: rtl/dsq_counter.sv
module dsq_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + ONE;
  end

  // R8: one increment per committed step, wrapping
  a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
    inc |=> (cnt_q == $past(cnt_q) + ONE));

  // R8: no movement without a committed step
  a_r8_count_hold: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(cnt_q));
endmodule

// File: rtl/dsq_pc_seq.sv
module dsq_pc_seq
  import dsq_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter int                CNT_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = ADDR_W'(32'h0000_1000)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              retire_i,
  input  logic              excp_i,
  input  logic              tgt_vld_i,
  input  logic [ADDR_W-1:0] tgt_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              pend_vld_o,
  output logic [ADDR_W-1:0] pend_tgt_o,
  output logic [CNT_W-1:0]  count_o
);
  step_kind_e        kind;
  logic              commit;
  logic [ADDR_W-1:0] pc_nxt;
  logic              pend_vld_nxt;
  logic [ADDR_W-1:0] pend_tgt_nxt;

  dsq_next #(.ADDR_W(ADDR_W)) u_next (
    .retire       (retire_i),
    .excp         (excp_i),
    .tgt_vld      (tgt_vld_i),
    .tgt          (tgt_i),
    .pc           (pc_o),
    .pend_vld     (pend_vld_o),
    .pend_tgt     (pend_tgt_o),
    .kind         (kind),
    .commit       (commit),
    .pc_nxt       (pc_nxt),
    .pend_vld_nxt (pend_vld_nxt),
    .pend_tgt_nxt (pend_tgt_nxt)
  );

  dsq_state #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_state (
    .clk          (clk),
    .rst          (rst),
    .commit       (commit),
    .retire       (retire_i),
    .pc_nxt       (pc_nxt),
    .pend_vld_nxt (pend_vld_nxt),
    .pend_tgt_nxt (pend_tgt_nxt),
    .pc_q         (pc_o),
    .pend_vld_q   (pend_vld_o),
    .pend_tgt_q   (pend_tgt_o)
  );

  dsq_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (commit),
    .cnt_q (count_o)
  );

  // R5: a target from a non-slot instruction becomes pending, PC goes sequential
  a_r5_arm: assert property (@(posedge clk) disable iff (rst)
    (retire_i && !excp_i && !pend_vld_o && tgt_vld_i)
      |=> (pend_vld_o && pend_tgt_o == $past(tgt_i)));

  // R7: a target offered in the delay slot never survives the step
  a_r7_slot_drop: assert property (@(posedge clk) disable iff (rst)
    (retire_i && !excp_i && pend_vld_o && tgt_vld_i) |=> !pend_vld_o);

  // R4: plain committed step leaves nothing pending
  a_r4_plain_empty: assert property (@(posedge clk) disable iff (rst)
    (retire_i && !excp_i && !pend_vld_o && !tgt_vld_i) |=> !pend_vld_o);
endmodule

// File: tb/dsq_pc_seq_tb.sv
module dsq_pc_seq_tb;
  localparam int              AW  = 32;
  localparam int              CW  = 4;
  localparam logic [AW-1:0]   RPC = 32'h0000_1000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          retire_i = 1'b0;
  logic          excp_i = 1'b0;
  logic          tgt_vld_i = 1'b0;
  logic [AW-1:0] tgt_i = '0;
  logic [AW-1:0] pc_o;
  logic          pend_vld_o;
  logic [AW-1:0] pend_tgt_o;
  logic [CW-1:0] count_o;

  always #4 clk = ~clk;  // 125 MHz

  dsq_pc_seq #(.ADDR_W(AW), .CNT_W(CW), .RESET_PC(RPC)) u_dut (
    .clk(clk), .rst(rst), .retire_i(retire_i), .excp_i(excp_i),
    .tgt_vld_i(tgt_vld_i), .tgt_i(tgt_i), .pc_o(pc_o),
    .pend_vld_o(pend_vld_o), .pend_tgt_o(pend_tgt_o), .count_o(count_o)
  );

  typedef struct {
    string         req;
    logic [AW-1:0] pc;
    logic          pv;
    logic [AW-1:0] pt;
    logic [CW-1:0] cnt;
  } exp_t;

  exp_t q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;

  // bench-side model
  logic [AW-1:0] m_pc;
  logic          m_pv;
  logic [AW-1:0] m_pt;
  logic [CW-1:0] m_cnt;

  task automatic check(string req, exp_t e);
    n_tests++;
    if (pc_o !== e.pc || pend_vld_o !== e.pv || pend_tgt_o !== e.pt || count_o !== e.cnt) begin
      n_fail++;
      $display("FAIL %s: got pc=%h pv=%b pt=%h cnt=%0d, exp pc=%h pv=%b pt=%h cnt=%0d",
               req, pc_o, pend_vld_o, pend_tgt_o, count_o, e.pc, e.pv, e.pt, e.cnt);
    end
  endtask

  // driver: one clock of stimulus, pushes the expected post-edge state
  task automatic drive(bit ret, bit ex, bit tv, logic [AW-1:0] t, string req);
    exp_t e;
    @(negedge clk);
    retire_i = ret; excp_i = ex; tgt_vld_i = tv; tgt_i = t;
    if (ret && !ex) begin
      if (m_pv) begin
        m_pc = m_pt; m_pv = 1'b0;
      end else begin
        m_pc = m_pc + 32'd4;
        if (tv) begin m_pv = 1'b1; m_pt = t; end
      end
      m_cnt = m_cnt + 1'b1;
    end
    e.req = req; e.pc = m_pc; e.pv = m_pv; e.pt = m_pt; e.cnt = m_cnt;
    q.push_back(e);
  endtask

  // monitor: samples just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.req, e);
      end
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    // R1: reset state
    r.req = "R1"; r.pc = RPC; r.pv = 1'b0; r.pt = '0; r.cnt = '0;
    check("R1", r);
    m_pc = RPC; m_pv = 1'b0; m_pt = '0; m_cnt = '0;

    drive(0, 0, 1, 32'h0000_2000, "R2");           // idle ignores target
    drive(1, 0, 0, '0, "R4");                      // plain step
    drive(1, 1, 1, 32'h0000_3000, "R3");           // faulting branch discarded
    drive(1, 0, 1, 32'h0000_4000, "R5");           // branch arms pending
    drive(0, 0, 0, '0, "R2");                      // idle with pending
    drive(1, 1, 0, '0, "R3");                      // faulting delay slot
    drive(1, 0, 0, '0, "R6");                      // delay slot commits, redirect
    drive(1, 0, 1, 32'h0000_5000, "R5");           // branch arms
    drive(1, 0, 1, 32'h0000_6000, "R7");           // slot offers target, dropped
    drive(1, 0, 0, '0, "R4");                      // back to sequential
    // R9: PC wrap through the top of the address space
    drive(1, 0, 1, 32'hFFFF_FFFC, "R5");
    drive(1, 0, 0, '0, "R6");
    drive(1, 0, 0, '0, "R9");
    // R8: drive enough commits to wrap the 4-bit count
    for (int i = 0; i < 20; i++) drive(1, 0, 0, '0, "R8");
    // mixed random traffic
    for (int i = 0; i < 2000; i++) begin
      bit rr = ($urandom % 4) != 0;
      bit ee = ($urandom % 6) == 0;
      bit tt = ($urandom % 3) == 0;
      logic [AW-1:0] tg = {$urandom} & 32'hFFFF_FFFC;
      string tag;
      if (!rr) tag = "R2";
      else if (ee) tag = "R3";
      else if (m_pv && tt) tag = "R7";
      else if (m_pv) tag = "R6";
      else if (tt) tag = "R5";
      else tag = "R4";
      drive(rr, ee, tt, tg, tag);
    end
    drive(0, 0, 0, '0, "R2");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule